// File: doc/BRIEF.md
# Packet Statistics Counters with Snapshot

This block keeps six event counters for a packet client: start-of-packet, end-of-packet and errored-packet counts, for both a transmit stream and a receive stream. Each counter is two register words wide. Software reads the count as a low word and a high word through a simple register port. Read data returns one cycle after the request.

A control register at offset zero holds three things. The first is a generator command field, which is decoded into a stop request for the packet generator. The second is a snapshot bit. When software sets it, the block takes a coherent copy of all six counters, so the low and high words always belong to the same value while the live counters keep running. The third is a self-clearing clear bit, which zeroes every counter and every copy.

Top module: `pkt_stats`

## Requirements
- R1: During and after a synchronous reset (`rst` high), every counter and every captured copy is zero, the control register reads 0x00, `gen_stop` is low, `gen_cmd` is 0 and `rdata_valid` is low.
- R2: Each start-of-packet or end-of-packet strobe adds exactly one to its own counter. A start strobe and an end strobe in the same cycle each count.
- R3: The error counter of a direction adds one only on a cycle where both that direction's end-of-packet strobe and error flag are high. An error flag without an end strobe changes no counter.
- R4: Counter k sits at byte offset 0x20 + 8*k, in the order transmit start, transmit end, transmit error, receive start, receive end, receive error (k = 0..5). At that offset the read returns count bits [W-1:0]. At offset + 4 it returns bits [2W-1:W], where W is the word width.
- R5: The control register is at offset 0x00. Bits [2:0] hold the generator command and bit 6 holds the snapshot bit, and both read back as written. Bit 7 and bits [5:3] always read 0.
- R6: A write that takes bit 6 from 0 to 1 captures every counter as counted up to the cycle before that write. While bit 6 stays 1, counter reads return the captured values, and a further write keeping bit 6 at 1 does not capture again.
- R7: While bit 6 is 0, counter reads return the live counts. Events that arrive during a snapshot are kept.
- R8: Writing 1 to control bit 7 zeroes all live counters and all captured copies at that clock edge. This takes priority over any strobe in the same cycle. The bit is not stored.
- R9: `gen_cmd` follows control bits [2:0]. `gen_stop` is high exactly while that field holds 3'b100.
- R10: `rdata_valid` is high in the cycle after a read request and low otherwise. Reads of unmapped offsets return zero: 0x04 to 0x1C, offsets above 0x4C, and any offset that is not a multiple of 4.
- R11: A counter is 2W bits wide. It carries from the low word into the high word and wraps modulo 2^(2W).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write request |
| rd_en | input | 1 | Register read request |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | WORD_W | Write data |
| rdata | output | WORD_W | Read data, valid one cycle after `rd_en` |
| rdata_valid | output | 1 | Marks `rdata` as the answer to the previous request |
| tx_sop | input | 1 | Transmit start-of-packet strobe |
| tx_eop | input | 1 | Transmit end-of-packet strobe |
| tx_err | input | 1 | Transmit error flag, counted with `tx_eop` |
| rx_sop | input | 1 | Receive start-of-packet strobe |
| rx_eop | input | 1 | Receive end-of-packet strobe |
| rx_err | input | 1 | Receive error flag, counted with `rx_eop` |
| gen_cmd | output | 3 | Generator command field |
| gen_stop | output | 1 | Generator stop request |

## Verification
The bench builds the block with an 8-bit word, which gives 16-bit counters and an 8-bit offset. With that width, a few hundred strobes carry a count into the high word. This makes the wrap path reachable, and it shows that a snapshot keeps both halves stable while the live count runs far past the captured value. The offset width and the control bit positions are the same as at the default width, so the register map under test is the real one.

// File: rtl/pkt_stats_pkg.sv
package pkt_stats_pkg;

    localparam int NUM_DIR       = 2;
    localparam int STATS_PER_DIR = 3;
    localparam int NUM_STATS     = NUM_DIR * STATS_PER_DIR;

    localparam logic [31:0] STAT_BASE = 32'h20;
    localparam int          SLOT_SPAN = 8;

    localparam int          CMD_W    = 3;
    localparam int          SNAP_BIT = 6;
    localparam int          CLR_BIT  = 7;
    localparam logic [2:0]  CMD_STOP = 3'b100;

    typedef enum logic [1:0] {
        EV_SOP = 2'd0,
        EV_EOP = 2'd1,
        EV_ERR = 2'd2
    } ev_kind_t;

    typedef struct packed {
        logic sop;
        logic eop;
        logic err;
    } ev_strobe_t;

    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic             snap;
    } ctrl_t;

    typedef struct packed {
        logic       hit;
        logic [2:0] slot;
        logic       hi;
    } stat_sel_t;

    // Map a byte offset onto a counter slot and word half.
    function automatic stat_sel_t decode_stat(input logic [31:0] ofs);
        stat_sel_t  s;
        logic [31:0] rel;
        rel    = ofs - STAT_BASE;
        s.hit  = (ofs >= STAT_BASE) &&
                 (rel < 32'(NUM_STATS * SLOT_SPAN)) &&
                 (ofs[1:0] == 2'b00);
        s.slot = rel[5:3];
        s.hi   = rel[2];
        return s;
    endfunction

endpackage

// File: rtl/pkt_stats_ctr.sv
module pkt_stats_ctr #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             take,
    input  logic             inc,
    output logic [CNT_W-1:0] live,
    output logic [CNT_W-1:0] shadow
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            live <= '0;
        end else if (inc) begin
            live <= live + CNT_W'(1);
        end
    end

    // The copy takes the count as it stood before the capturing edge.
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            shadow <= '0;
        end else if (take) begin
            shadow <= live;
        end
    end

endmodule

// File: rtl/pkt_stats_dir.sv
module pkt_stats_dir
    import pkt_stats_pkg::*;
#(
    parameter int CNT_W = 64
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                clr,
    input  logic                                take,
    input  ev_strobe_t                          ev,
    output logic [STATS_PER_DIR-1:0][CNT_W-1:0] live,
    output logic [STATS_PER_DIR-1:0][CNT_W-1:0] shadow
);

    logic [STATS_PER_DIR-1:0] inc;

    always_comb begin
        inc         = '0;
        inc[EV_SOP] = ev.sop;
        inc[EV_EOP] = ev.eop;
        inc[EV_ERR] = ev.eop && ev.err;
    end

    for (genvar k = 0; k < STATS_PER_DIR; k++) begin : g_ctr
        pkt_stats_ctr #(.CNT_W(CNT_W)) u_ctr (
            .clk    (clk),
            .rst    (rst),
            .clr    (clr),
            .take   (take),
            .inc    (inc[k]),
            .live   (live[k]),
            .shadow (shadow[k])
        );
    end

endmodule

// File: rtl/pkt_stats_ctl.sv
module pkt_stats_ctl
    import pkt_stats_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic              clr,
    output logic              take
);

    logic ctrl_wr;
    logic unused_wbits;

    assign ctrl_wr      = wr_en && (addr == '0);
    assign clr          = ctrl_wr && wdata[CLR_BIT];
    assign take         = ctrl_wr && wdata[SNAP_BIT] && !ctrl.snap;
    assign unused_wbits = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl.cmd  <= wdata[CMD_W-1:0];
            ctrl.snap <= wdata[SNAP_BIT];
        end
    end

endmodule

// File: rtl/pkt_stats_rd.sv
module pkt_stats_rd
    import pkt_stats_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 2 * WORD_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               addr,
    input  ctrl_t                           ctrl,
    input  logic [NUM_STATS-1:0][CNT_W-1:0] live,
    input  logic [NUM_STATS-1:0][CNT_W-1:0] shadow,
    output logic [WORD_W-1:0]               rdata,
    output logic                            rdata_valid
);

    stat_sel_t          sel;
    logic [CNT_W-1:0]   src;
    logic [WORD_W-1:0]  word;

    always_comb begin
        sel = decode_stat(32'(addr));
        src = '0;
        for (int k = 0; k < NUM_STATS; k++) begin
            if (sel.slot == 3'(k)) begin
                src = ctrl.snap ? shadow[k] : live[k];
            end
        end
        word = '0;
        if (addr == '0) begin
            word[CMD_W-1:0] = ctrl.cmd;
            word[SNAP_BIT]  = ctrl.snap;
        end else if (sel.hit) begin
            word = sel.hi ? src[CNT_W-1:WORD_W] : src[WORD_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata       <= '0;
            rdata_valid <= 1'b0;
        end else begin
            rdata_valid <= rd_en;
            if (rd_en) begin
                rdata <= word;
            end
        end
    end

endmodule

// File: rtl/pkt_stats.sv
module pkt_stats
    import pkt_stats_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rdata_valid,
    input  logic              tx_sop,
    input  logic              tx_eop,
    input  logic              tx_err,
    input  logic              rx_sop,
    input  logic              rx_eop,
    input  logic              rx_err,
    output logic [2:0]        gen_cmd,
    output logic              gen_stop
);

    localparam int CNT_W = 2 * WORD_W;

    ctrl_t                           ctrl_q;
    logic                            ctl_clr;
    logic                            ctl_take;
    ev_strobe_t [NUM_DIR-1:0]        ev;
    logic [NUM_STATS-1:0][CNT_W-1:0] live_cnt;
    logic [NUM_STATS-1:0][CNT_W-1:0] snap_cnt;

    assign ev[0] = '{sop: tx_sop, eop: tx_eop, err: tx_err};
    assign ev[1] = '{sop: rx_sop, eop: rx_eop, err: rx_err};

    pkt_stats_ctl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .ctrl  (ctrl_q),
        .clr   (ctl_clr),
        .take  (ctl_take)
    );

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        pkt_stats_dir #(.CNT_W(CNT_W)) u_dir (
            .clk    (clk),
            .rst    (rst),
            .clr    (ctl_clr),
            .take   (ctl_take),
            .ev     (ev[d]),
            .live   (live_cnt[d*STATS_PER_DIR +: STATS_PER_DIR]),
            .shadow (snap_cnt[d*STATS_PER_DIR +: STATS_PER_DIR])
        );
    end

    pkt_stats_rd #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .rd_en       (rd_en),
        .addr        (addr),
        .ctrl        (ctrl_q),
        .live        (live_cnt),
        .shadow      (snap_cnt),
        .rdata       (rdata),
        .rdata_valid (rdata_valid)
    );

    assign gen_cmd  = ctrl_q.cmd;
    assign gen_stop = (ctrl_q.cmd == CMD_STOP);

endmodule

// File: rtl/pkt_stats_chk.sv
module pkt_stats_chk #(
    parameter int WORD_W = 32,
    parameter int ADDR_W = 8,
    parameter int CNT_W  = 2 * WORD_W
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_en,
    input logic                    rd_en,
    input logic [ADDR_W-1:0]       addr,
    input logic [WORD_W-1:0]       wdata,
    input logic                    rdata_valid,
    input logic                    gen_stop,
    input logic                    tx_sop,
    input logic                    tx_eop,
    input logic                    clr,
    input logic                    snap_on,
    input logic [5:0][CNT_W-1:0]   live_cnt,
    input logic [5:0][CNT_W-1:0]   snap_cnt
);

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (!rdata_valid && !gen_stop && !snap_on && live_cnt == '0));

    p_sop_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_sop && !clr) |=> live_cnt[0] == $past(live_cnt[0]) + CNT_W'(1));

    p_err_needs_eop_r3: assert property (@(posedge clk) disable iff (rst)
        (!tx_eop && !clr) |=> $stable(live_cnt[2]));

    p_snap_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        (snap_on && !clr) |=> $stable(snap_cnt));

    p_clear_zeroes_r8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (live_cnt == '0 && snap_cnt == '0));

    p_stop_cmd_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == '0 && wdata[2:0] == 3'b100) |=> gen_stop);

    p_valid_after_read_r10: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rdata_valid);

    p_valid_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rdata_valid);

endmodule

bind pkt_stats pkt_stats_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata_valid (rdata_valid),
    .gen_stop    (gen_stop),
    .tx_sop      (tx_sop),
    .tx_eop      (tx_eop),
    .clr         (ctl_clr),
    .snap_on     (ctrl_q.snap),
    .live_cnt    (live_cnt),
    .snap_cnt    (snap_cnt)
);

// File: tb/pkt_stats_tb.sv
module pkt_stats_tb;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 8;
    localparam int AW         = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en, rd_en;
    logic [AW-1:0] addr;
    logic [W-1:0]  wdata;
    logic [W-1:0]  rdata;
    logic          rdata_valid;
    logic          tx_sop, tx_eop, tx_err, rx_sop, rx_eop, rx_err;
    logic [2:0]    gen_cmd;
    logic          gen_stop;

    int n_checks = 0;
    int n_err    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_stats #(.WORD_W(W), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rdata_valid(rdata_valid),
        .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_err(tx_err),
        .rx_sop(rx_sop), .rx_eop(rx_eop), .rx_err(rx_err),
        .gen_cmd(gen_cmd), .gen_stop(gen_stop)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [W-1:0] exp);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        check({req, " valid"}, 32'(rdata_valid), 32'd1);
        check(req, 32'(rdata), 32'(exp));
    endtask

    // k: 0 tx sop, 1 tx eop, 2 tx err, 3 rx sop, 4 rx eop, 5 rx err
    task automatic cnt_chk(input string req, input int k, input logic [2*W-1:0] exp);
        rd_chk({req, " lo"}, AW'(32'h20 + 8*k),     exp[W-1:0]);
        rd_chk({req, " hi"}, AW'(32'h20 + 8*k + 4), exp[2*W-1:W]);
    endtask

    // m = {tx_sop, tx_eop, tx_err, rx_sop, rx_eop, rx_err}
    task automatic pulse(input logic [5:0] m, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            {tx_sop, tx_eop, tx_err, rx_sop, rx_eop, rx_err} = m;
            @(negedge clk);
            {tx_sop, tx_eop, tx_err, rx_sop, rx_eop, rx_err} = '0;
        end
    endtask

    task automatic t_reset();
        check("R1 valid low", 32'(rdata_valid), 32'd0);
        check("R1 gen_stop low", 32'(gen_stop), 32'd0);
        check("R1 gen_cmd zero", 32'(gen_cmd), 32'd0);
        rd_chk("R1 ctrl", 8'h00, 8'h00);
        for (int k = 0; k < 6; k++) cnt_chk("R1 count", k, 16'd0);
    endtask

    task automatic t_run16();
        wr(8'h00, 8'h80);
        for (int i = 0; i < 16; i++) begin
            if (i % 2 == 0) begin
                pulse(6'b100_100, 1);
                pulse(6'b010_010, 1);
            end else begin
                pulse(6'b110_110, 1); // R2: start and end together
            end
        end
        wr(8'h00, 8'h40);
        cnt_chk("R2 tx sop", 0, 16'd16);
        cnt_chk("R2 tx eop", 1, 16'd16);
        cnt_chk("R3 tx err", 2, 16'd0);
        cnt_chk("R2 rx sop", 3, 16'd16);
        cnt_chk("R2 rx eop", 4, 16'd16);
        cnt_chk("R3 rx err", 5, 16'd0);
        wr(8'h00, 8'h04);
        check("R9 gen_stop", 32'(gen_stop), 32'd1);
        check("R9 gen_cmd", 32'(gen_cmd), 32'd4);
        wr(8'h00, 8'h00);
    endtask

    task automatic t_errors();
        wr(8'h00, 8'h80);
        pulse(6'b001_000, 3);
        pulse(6'b000_001, 2);
        cnt_chk("R3 tx err alone", 2, 16'd0);
        cnt_chk("R3 rx err alone", 5, 16'd0);
        pulse(6'b011_000, 2);
        pulse(6'b000_011, 1);
        pulse(6'b000_010, 1);
        cnt_chk("R3 tx err", 2, 16'd2);
        cnt_chk("R3 tx eop", 1, 16'd2);
        cnt_chk("R3 rx err", 5, 16'd1);
        cnt_chk("R3 rx eop", 4, 16'd2);
        cnt_chk("R4 tx sop untouched", 0, 16'd0);
    endtask

    task automatic t_snapshot_wrap();
        wr(8'h00, 8'h80);
        pulse(6'b000_100, 20);
        wr(8'h00, 8'h40);
        pulse(6'b100_100, 300);
        cnt_chk("R6 rx sop frozen", 3, 16'd20);
        cnt_chk("R6 tx sop frozen", 0, 16'd0);
        wr(8'h00, 8'h40);
        cnt_chk("R6 no recapture", 3, 16'd20);
        wr(8'h00, 8'h00);
        cnt_chk("R7 R11 rx sop live", 3, 16'd320);
        cnt_chk("R7 R11 tx sop live", 0, 16'd300);
    endtask

    task automatic t_clear();
        @(negedge clk);
        wr_en = 1'b1; addr = 8'h00; wdata = 8'h80;
        {tx_sop, tx_eop, tx_err, rx_sop, rx_eop, rx_err} = 6'b111_111;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
        {tx_sop, tx_eop, tx_err, rx_sop, rx_eop, rx_err} = '0;
        cnt_chk("R8 tx sop", 0, 16'd0);
        cnt_chk("R8 tx err", 2, 16'd0);
        cnt_chk("R8 rx sop", 3, 16'd0);
        pulse(6'b100_000, 5);
        wr(8'h00, 8'h40);
        cnt_chk("R6 snap of five", 0, 16'd5);
        wr(8'h00, 8'hC0);
        cnt_chk("R8 snapshot cleared", 0, 16'd0);
        rd_chk("R8 ctrl after clear", 8'h00, 8'h40);
        wr(8'h00, 8'h00);
        cnt_chk("R8 live cleared", 0, 16'd0);
    endtask

    task automatic t_ctrl();
        wr(8'h00, 8'h47);
        rd_chk("R5 ctrl 0x47", 8'h00, 8'h47);
        check("R9 gen_cmd 7", 32'(gen_cmd), 32'd7);
        check("R9 no stop on 7", 32'(gen_stop), 32'd0);
        wr(8'h00, 8'h3B);
        rd_chk("R5 reserved bits", 8'h00, 8'h03);
        check("R9 no stop on 3", 32'(gen_stop), 32'd0);
        wr(8'h00, 8'hC4);
        rd_chk("R5 clear bit not stored", 8'h00, 8'h44);
        check("R9 stop on 4", 32'(gen_stop), 32'd1);
        wr(8'h00, 8'h00);
        check("R9 stop released", 32'(gen_stop), 32'd0);
    endtask

    task automatic t_unmapped();
        pulse(6'b100_100, 3);
        rd_chk("R10 off 0x04", 8'h04, 8'h00);
        rd_chk("R10 off 0x1C", 8'h1C, 8'h00);
        rd_chk("R10 off 0x21", 8'h21, 8'h00);
        rd_chk("R10 off 0x3A", 8'h3A, 8'h00);
        rd_chk("R10 off 0x50", 8'h50, 8'h00);
        rd_chk("R10 off 0xFC", 8'hFC, 8'h00);
        rd_chk("R4 tx sop mapped", 8'h20, 8'h03);
        rd_chk("R4 rx sop mapped", 8'h38, 8'h03);
        @(negedge clk);
        check("R10 valid idle", 32'(rdata_valid), 32'd0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        {tx_sop, tx_eop, tx_err, rx_sop, rx_eop, rx_err} = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_run16();
        t_errors();
        t_snapshot_wrap();
        t_clear();
        t_ctrl();
        t_unmapped();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule